// File: doc/BRIEF.md
# DMA Request Router and Channel Interrupt Summary

This block sits between a large set of peripheral DMA request lines and a small bank of DMA channels. Each peripheral owns one mapping entry. An entry holds an enable flag and a channel number. While the flag is set, that peripheral's request line is steered onto the named channel's request output. Several peripherals may point at the same channel, and their requests then merge by OR. An entry with its flag clear routes its request nowhere, so software unmaps a peripheral by writing zero to its entry.

The same block collects one interrupt line from each channel into a summary register. The register holds one bit per channel, and a single combined interrupt output is the OR of all those bits. A bit is set when its channel's interrupt line rises. Software reads the summary and writes the same value back. That write clears exactly the channels it has serviced and leaves alone any channel that raised an interrupt after the read.

All outputs are registered. The register port has one cycle of read latency. The channel engines themselves live outside this block.

Top module: `dma_req_router`

## Requirements
- R1: After a synchronous reset, every mapping entry reads 0, the summary reads 0, all channel request outputs are 0 and the combined interrupt output is 0.
- R2: Mapping entry p (0 to 39) sits at register address p. Bit 7 is the enable flag and bits 3:0 are the target channel. Bits 6:4 and 31:8 are not stored and read as 0. Read data appears one cycle after the address is presented.
- R3: A peripheral whose entry has bit 7 clear drives no channel request, whatever channel number the entry holds. Writing 0 to an entry unmaps it.
- R4: A peripheral whose entry has bit 7 set drives the request output of its channel. The output follows the peripheral request input one clock later.
- R5: When several enabled entries name the same channel, that channel's request output is the OR of their request inputs.
- R6: The summary register is at address 64, with bit c belonging to channel c (bit 0 is channel 0). A rising edge on channel c's interrupt input sets bit c, visible after the next clock edge.
- R7: A write to address 64 clears each summary bit written as 1 and leaves each bit written as 0. Writing back a value that was read clears exactly those channels.
- R8: A write of 1 does not clear a summary bit while that channel's interrupt input is high in the same cycle.
- R9: The combined interrupt output is high exactly when at least one summary bit is set. It updates on the same clock edge as the summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register address (entries 0..39, summary 64) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data for the previous cycle's address |
| periph_req_i | input | 40 | Peripheral DMA request lines |
| chan_req_o | output | 16 | Registered per-channel request outputs |
| chan_irq_i | input | 16 | Per-channel interrupt lines |
| irq_o | output | 1 | Combined interrupt, OR of summary bits |

## Verification
The bench maps every peripheral to a scattered channel and drives each request line alone, so a swapped index or a wrong channel decode lights the wrong output. It then loads entries with channel numbers but the enable flag clear. A router that ignores the flag would assert requests there, and a write of zero that fails to unmap would leave a stale route. Two peripherals are pointed at one channel to show that the router merges them by OR rather than letting the last entry win. In the interrupt tests, the write-back of a read value is issued while one channel's line is still high. A summary that clears without checking the live line would lose that interrupt, and a combined output that lags or ignores a bit shows up in the same sequence.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  // Layout of one mapping entry as seen on the register port.
  localparam int ENTRY_W   = 8;
  localparam int VALID_BIT = 7;

  typedef struct packed {
    logic       valid;
    logic [6:0] chan;
  } map_entry_t;

  function automatic map_entry_t decode_entry(input logic [ENTRY_W-1:0] raw);
    map_entry_t e;
    e.valid = raw[VALID_BIT];
    e.chan  = raw[6:0];
    return e;
  endfunction
endpackage

// File: rtl/dmr_map_table.sv
module dmr_map_table
  import dmr_pkg::*;
#(
  parameter int NUM_PERIPH = 40,
  parameter int NUM_CHAN   = 16,
  parameter int ADDR_W     = 7,
  localparam int CHAN_W    = $clog2(NUM_CHAN)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [ENTRY_W-1:0]           wdata_i,
  output logic [NUM_PERIPH-1:0]        valid_o,
  output logic [NUM_PERIPH*CHAN_W-1:0] chan_o
);
  map_entry_t wr_entry;
  assign wr_entry = decode_entry(wdata_i);

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_o[p]                  <= 1'b0;
        chan_o[p*CHAN_W +: CHAN_W]  <= '0;
      end else if (we_i && (int'(addr_i) == p)) begin
        valid_o[p]                  <= wr_entry.valid;
        chan_o[p*CHAN_W +: CHAN_W]  <= wr_entry.chan[CHAN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dmr_req_xbar.sv
module dmr_req_xbar #(
  parameter int NUM_PERIPH = 40,
  parameter int NUM_CHAN   = 16,
  localparam int CHAN_W    = $clog2(NUM_CHAN)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_PERIPH-1:0]        req_i,
  input  logic [NUM_PERIPH-1:0]        valid_i,
  input  logic [NUM_PERIPH*CHAN_W-1:0] chan_i,
  output logic [NUM_CHAN-1:0]          req_o
);
  logic [NUM_CHAN-1:0] req_d;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    always_comb begin
      req_d[c] = 1'b0;
      for (int p = 0; p < NUM_PERIPH; p++) begin
        if (req_i[p] && valid_i[p] &&
            (chan_i[p*CHAN_W +: CHAN_W] == CHAN_W'(c)))
          req_d[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) req_o <= '0;
    else     req_o <= req_d;
  end
endmodule

// File: rtl/dmr_irq_summary.sv
module dmr_irq_summary #(
  parameter int NUM_CHAN = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CHAN-1:0] irq_i,
  input  logic                clr_we_i,
  input  logic [NUM_CHAN-1:0] clr_mask_i,
  output logic [NUM_CHAN-1:0] sum_o,
  output logic                irq_o
);
  logic [NUM_CHAN-1:0] irq_prev, rise, clr_eff, sum_d;

  assign rise    = irq_i & ~irq_prev;
  assign clr_eff = clr_we_i ? (clr_mask_i & ~irq_i) : '0;
  assign sum_d   = (sum_o & ~clr_eff) | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_prev <= '0;
      sum_o    <= '0;
      irq_o    <= 1'b0;
    end else begin
      irq_prev <= irq_i;
      sum_o    <= sum_d;
      irq_o    <= |sum_d;
    end
  end
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dmr_pkg::*;
#(
  parameter int NUM_PERIPH = 40,
  parameter int NUM_CHAN   = 16,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32,
  parameter int SUM_ADDR   = 64,
  localparam int CHAN_W    = $clog2(NUM_CHAN)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic [NUM_PERIPH-1:0] periph_req_i,
  output logic [NUM_CHAN-1:0]   chan_req_o,
  input  logic [NUM_CHAN-1:0]   chan_irq_i,
  output logic                  irq_o
);
  logic [NUM_PERIPH-1:0]        map_valid;
  logic [NUM_PERIPH*CHAN_W-1:0] map_chan;
  logic [NUM_CHAN-1:0]          sum_q;
  logic                         sum_wr;
  logic [DATA_W-1:0]            rdata_d;

  assign sum_wr = reg_we_i && (int'(reg_addr_i) == SUM_ADDR);

  dmr_map_table #(
    .NUM_PERIPH(NUM_PERIPH), .NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)
  ) table_i (
    .clk(clk), .rst(rst), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i[ENTRY_W-1:0]),
    .valid_o(map_valid), .chan_o(map_chan)
  );

  dmr_req_xbar #(
    .NUM_PERIPH(NUM_PERIPH), .NUM_CHAN(NUM_CHAN)
  ) xbar_i (
    .clk(clk), .rst(rst), .req_i(periph_req_i),
    .valid_i(map_valid), .chan_i(map_chan), .req_o(chan_req_o)
  );

  dmr_irq_summary #(
    .NUM_CHAN(NUM_CHAN)
  ) summary_i (
    .clk(clk), .rst(rst), .irq_i(chan_irq_i),
    .clr_we_i(sum_wr), .clr_mask_i(reg_wdata_i[NUM_CHAN-1:0]),
    .sum_o(sum_q), .irq_o(irq_o)
  );

  always_comb begin
    rdata_d = '0;
    if (int'(reg_addr_i) == SUM_ADDR) begin
      rdata_d[NUM_CHAN-1:0] = sum_q;
    end else begin
      for (int p = 0; p < NUM_PERIPH; p++) begin
        if (int'(reg_addr_i) == p) begin
          rdata_d[VALID_BIT]    = map_valid[p];
          rdata_d[CHAN_W-1:0]   = map_chan[p*CHAN_W +: CHAN_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata_o <= '0;
    else     reg_rdata_o <= rdata_d;
  end
endmodule

// File: rtl/dmr_checker.sv
module dmr_checker #(
  parameter int NUM_PERIPH = 40,
  parameter int NUM_CHAN   = 16,
  parameter int ADDR_W     = 7,
  parameter int SUM_ADDR   = 64
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_we_i,
  input logic [ADDR_W-1:0]     reg_addr_i,
  input logic [NUM_PERIPH-1:0] periph_req_i,
  input logic [NUM_CHAN-1:0]   chan_req_o,
  input logic [NUM_CHAN-1:0]   chan_irq_i,
  input logic [NUM_CHAN-1:0]   sum_q,
  input logic                  irq_o
);
  logic [NUM_CHAN-1:0] irq_seen;
  logic [NUM_CHAN-1:0] edge_now;

  always_ff @(posedge clk) begin
    if (rst) irq_seen <= '0;
    else     irq_seen <= chan_irq_i;
  end
  assign edge_now = chan_irq_i & ~irq_seen;

  // R1: outputs quiet right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (chan_req_o == '0 && sum_q == '0 && !irq_o));

  // R3, R4: no channel request without some peripheral request one cycle before
  a_r3_no_spurious_req: assert property (@(posedge clk) disable iff (rst)
    (periph_req_i == '0) |=> (chan_req_o == '0));

  // R6: a rising interrupt line sets its summary bit on the next edge
  a_r6_rise_sets: assert property (@(posedge clk) disable iff (rst)
    (edge_now != '0) |=> ((sum_q & $past(edge_now)) == $past(edge_now)));

  // R7: summary bits only fall through a write to the summary address
  a_r7_clear_by_write: assert property (@(posedge clk) disable iff (rst)
    ((sum_q != '0) && !(reg_we_i && int'(reg_addr_i) == SUM_ADDR))
      |=> ((sum_q & $past(sum_q)) == $past(sum_q)));

  // R8: a set bit whose line is high survives any write
  a_r8_hold_while_high: assert property (@(posedge clk) disable iff (rst)
    ((sum_q & chan_irq_i) != '0) |=> ((sum_q & $past(sum_q & chan_irq_i)) == $past(sum_q & chan_irq_i)));

  // R9: combined output tracks the summary
  a_r9_irq_is_or: assert property (@(posedge clk) disable iff (rst)
    irq_o == (sum_q != '0));
endmodule

bind dma_req_router dmr_checker #(
  .NUM_PERIPH(NUM_PERIPH), .NUM_CHAN(NUM_CHAN),
  .ADDR_W(ADDR_W), .SUM_ADDR(SUM_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .periph_req_i(periph_req_i), .chan_req_o(chan_req_o),
  .chan_irq_i(chan_irq_i), .sum_q(sum_q), .irq_o(irq_o)
);

// File: tb/dma_req_router_tb.sv
module dma_req_router_tb_top;
  localparam int NP = 40;
  localparam int NC = 16;
  localparam int SA = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [6:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] periph_req = '0;
  logic [NC-1:0] chan_req;
  logic [NC-1:0] chan_irq = '0;
  logic          irq;

  int errors = 0;
  int checks = 0;
  logic [7:0] mdl [NP];

  always #2.5 clk = ~clk;

  dma_req_router dut_i (
    .clk(clk), .rst(rst), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .periph_req_i(periph_req), .chan_req_o(chan_req),
    .chan_irq_i(chan_irq), .irq_o(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 7'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a < NP) mdl[a] = d[7:0] & 8'h8F;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 7'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [NC-1:0] route(input logic [NP-1:0] r);
    logic [NC-1:0] o = '0;
    for (int p = 0; p < NP; p++)
      if (r[p] && mdl[p][7]) o[mdl[p][3:0]] = 1'b1;
    return o;
  endfunction

  task automatic drive_req(input logic [NP-1:0] r, input string tag);
    @(negedge clk);
    periph_req = r;
    @(negedge clk);
    check(tag, 64'(chan_req), 64'(route(r)));
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [NP-1:0] one;
    for (int p = 0; p < NP; p++) mdl[p] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 chan_req", 64'(chan_req), 0);
    check("R1 irq", 64'(irq), 0);
    for (int p = 0; p < NP; p++) begin rd(p, d); check("R1 entry", 64'(d), 0); end
    rd(SA, d); check("R1 summary", 64'(d), 0);

    // R2 readback with unstored bits
    wr(5, 32'hFFFF_FF7F); rd(5, d); check("R2 masked bits", 64'(d), 64'h0F);
    wr(5, 32'h0000_00FA); rd(5, d); check("R2 valid+chan", 64'(d), 64'h8A);

    // R4 sweep: every peripheral to a scattered channel
    for (int p = 0; p < NP; p++) wr(p, 32'h80 | 32'((p * 7 + 3) % NC));
    for (int p = 0; p < NP; p++) begin
      rd(p, d); check("R2 sweep readback", 64'(d), 64'(8'h80 | 8'((p * 7 + 3) % NC)));
    end
    for (int p = 0; p < NP; p++) begin
      one = '0; one[p] = 1'b1;
      drive_req(one, "R4 single route");
      check("R4 onehot", 64'(chan_req), 64'(16'b1 << ((p * 7 + 3) % NC)));
    end
    drive_req('1, "R5 all requests");

    // R3 entries holding a channel but no enable flag
    for (int p = 0; p < NP; p++) wr(p, 32'((p * 7 + 3) % NC));
    drive_req('1, "R3 disabled entries");
    check("R3 none routed", 64'(chan_req), 0);

    // R5 shared channel
    wr(3, 32'h89); wr(17, 32'h89);
    one = '0; one[3] = 1'b1;  drive_req(one, "R5 share a");
    one = '0; one[17] = 1'b1; drive_req(one, "R5 share b");
    one = '0; one[3] = 1'b1; one[17] = 1'b1; drive_req(one, "R5 share both");
    check("R5 bit9", 64'(chan_req), 64'h200);
    // R3 unmap by writing zero
    wr(3, 32'h0);
    one = '0; one[3] = 1'b1; drive_req(one, "R3 unmapped");
    check("R3 unmapped zero", 64'(chan_req), 0);
    drive_req('0, "R4 idle");

    // R6 rising edges set summary bits
    @(negedge clk); chan_irq = 16'h8021;
    @(negedge clk);
    check("R9 irq after set", 64'(irq), 1);
    rd(SA, d); check("R6 summary", 64'(d), 64'h8021);
    // R8 write-back while channel 5 still high
    @(negedge clk); chan_irq = 16'h0020;
    wr(SA, d);
    rd(SA, d); check("R8 held bit survives", 64'(d), 64'h0020);
    check("R9 irq still high", 64'(irq), 1);
    @(negedge clk); chan_irq = 16'h0000;
    wr(SA, 32'h0020);
    rd(SA, d); check("R7 cleared", 64'(d), 0);
    check("R9 irq low", 64'(irq), 0);

    // R7 selective clear, zero bits untouched
    @(negedge clk); chan_irq = 16'h0006;
    @(negedge clk); chan_irq = 16'h0000;
    rd(SA, d); check("R6 bits 1,2", 64'(d), 64'h6);
    wr(SA, 32'h2);
    rd(SA, d); check("R7 partial clear", 64'(d), 64'h4);
    check("R9 irq partial", 64'(irq), 1);
    wr(SA, 32'h4);
    rd(SA, d); check("R7 final clear", 64'(d), 0);

    // R6 each channel individually
    for (int c = 0; c < NC; c++) begin
      @(negedge clk); chan_irq = 16'(1 << c);
      @(negedge clk); chan_irq = '0;
      rd(SA, d); check("R6 per channel", 64'(d), 64'(1 << c));
      wr(SA, d);
      rd(SA, d); check("R7 per channel clear", 64'(d), 0);
    end

    // R1 reset again clears everything
    wr(0, 32'h85);
    @(negedge clk); chan_irq = 16'h1;
    @(negedge clk); rst = 1'b1; chan_irq = '0;
    @(negedge clk); rst = 1'b0;
    for (int p = 0; p < NP; p++) mdl[p] = 8'h00;
    rd(0, d); check("R1 entry after reset", 64'(d), 0);
    rd(SA, d); check("R1 summary after reset", 64'(d), 0);
    check("R1 irq after reset", 64'(irq), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule